// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the per-pin configuration of an eight-pin general-purpose port and turns it into pad controls. Software writes byte-wide registers over a simple single-cycle bus. Each register bit belongs to one pin. From those bits every pin gets four pad controls: output-driver enable, input-buffer enable, pull-up enable and pull-down enable. The block also drives the pad output value and returns the pad input value, gated by the input enable, for reading back.

Pins that a parameter mask marks as not GPIO-capable keep every GPIO control bit at zero. A per-pin function-select bit hands a pin to a peripheral. The peripheral's drive and pull requests then replace the GPIO settings, and the raw pad level is passed on to it. Pull resistors are only switched on while the output driver is off, whichever source controls the pin.

Top module: `pinctl_bank`

## Requirements
- R1: After reset, every register reads 0 and pad_oe, pad_ie, pad_pu, pad_pd and pad_out are all 0.
- R2: A read issued with bus_rd in one cycle returns its data on bus_rdata, with bus_rvalid high, in the next cycle only. The address map is: 0 input enable, 1 output enable, 2 pull enable, 3 pull direction (1 = up, 0 = down), 4 output data, 5 input data (read-only), 6 function select (1 = peripheral), 7 reads 0.
- R3: For a GPIO pin with output enable 1, pad_oe is 1, pad_out equals the output-data bit, and both pulls are off whatever the other bits hold.
- R4: For a GPIO pin with output enable 0 and pull enable 1, pad_pu is 1 when the pull-direction bit is 1 and pad_pd is 1 when it is 0. The two are never both high.
- R5: For a GPIO pin with output enable 0 and pull enable 0, no pull is on. pad_out is 0 on any pin whose pad_oe is 0.
- R6: pad_ie follows the input-enable bit of a GPIO pin. The input-data register returns pad_in where the input enable is 1 and 0 where it is 0.
- R7: On a pin outside CAP_MASK, the GPIO control bits (addresses 0 to 4) and the input-data bit always read 0, even after writes of 1. While its function select is 0, all of its pad controls stay 0.
- R8: With function select 1, a pin takes pad_oe, pad_out and its pulls from the per_* inputs under the same pull rule. Its pad_ie is 1, per_in carries pad_in, and its input-data bit reads 0. per_in is 0 on pins with function select 0.
- R9: A write to the input-data address changes no register and no pad control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | 8 | Pad input levels |
| per_oe | input | 8 | Peripheral output enable request |
| per_out | input | 8 | Peripheral output value |
| per_pull_en | input | 8 | Peripheral pull enable request |
| per_pull_up | input | 8 | Peripheral pull direction, 1 = up |
| per_in | output | 8 | Pad level handed to the peripheral |
| pad_oe | output | 8 | Output driver enable |
| pad_out | output | 8 | Output value |
| pad_ie | output | 8 | Input buffer enable |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |

## Verification
The hardest case to reach is a pin with conflicting settings: output enable set while pull enable and input enable are also set, on a pin that is not GPIO-capable or has been handed to a peripheral. No single write produces that. The stimulus writes all ones to every control register, so the stored bits of capable pins conflict and the masked pin has been pushed as hard as it can be. It then selects the peripheral for some pins with peripheral pull and drive requests that themselves conflict. The pad controls and read-backs are then compared pin by pin against an independent model.

// File: rtl/pinctl_pkg.sv
// Shared register address encoding for the pin control bank.
package pinctl_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_IEN  = 3'd0,
        REG_OEN  = 3'd1,
        REG_PEN  = 3'd2,
        REG_PDIR = 3'd3,
        REG_DOUT = 3'd4,
        REG_DIN  = 3'd5,
        REG_FSEL = 3'd6,
        REG_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/pinctl_regs.sv
// Register storage for the pin control bank.
// Holds the five GPIO control vectors and the function-select vector.
// Assumes: bits of pins outside CAP_MASK have no flop and read as 0.
// The function-select bit exists for every pin.
module pinctl_regs
    import pinctl_pkg::*;
#(
    parameter int               NPIN     = 8,
    parameter logic [NPIN-1:0]  CAP_MASK = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPIN-1:0]   wdata,
    output logic [NPIN-1:0]   ien,
    output logic [NPIN-1:0]   oen,
    output logic [NPIN-1:0]   pen,
    output logic [NPIN-1:0]   pdir,
    output logic [NPIN-1:0]   dout,
    output logic [NPIN-1:0]   fsel
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    genvar i;
    generate
        for (i = 0; i < NPIN; i++) begin : g_bit
            if (CAP_MASK[i]) begin : g_cap
                logic ien_q, oen_q, pen_q, pdir_q, dout_q;
                // Capture a GPIO control bit of this pin on a matching write.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        ien_q  <= 1'b0;
                        oen_q  <= 1'b0;
                        pen_q  <= 1'b0;
                        pdir_q <= 1'b0;
                        dout_q <= 1'b0;
                    end else if (wr) begin
                        if (sel == REG_IEN)  ien_q  <= wdata[i];
                        if (sel == REG_OEN)  oen_q  <= wdata[i];
                        if (sel == REG_PEN)  pen_q  <= wdata[i];
                        if (sel == REG_PDIR) pdir_q <= wdata[i];
                        if (sel == REG_DOUT) dout_q <= wdata[i];
                    end
                end
                assign ien[i]  = ien_q;
                assign oen[i]  = oen_q;
                assign pen[i]  = pen_q;
                assign pdir[i] = pdir_q;
                assign dout[i] = dout_q;
            end else begin : g_nocap
                assign ien[i]  = 1'b0;
                assign oen[i]  = 1'b0;
                assign pen[i]  = 1'b0;
                assign pdir[i] = 1'b0;
                assign dout[i] = 1'b0;
            end
        end
    endgenerate

    // Capture the function-select vector, present for every pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                      fsel <= '0;
        else if (wr && sel == REG_FSEL)  fsel <= wdata;
    end
endmodule

// File: rtl/pinctl_pin.sv
// Pad control decode for one pin.
// Picks the control source: peripheral when fsel is 1, GPIO bits when the pin
// is capable, otherwise the reset condition. Then applies the drive/pull rule:
// pulls only while the driver is off, and the output value is 0 while off.
module pinctl_pin #(
    parameter bit CAP = 1'b1
) (
    input  logic fsel,
    input  logic ien,
    input  logic oen,
    input  logic pen,
    input  logic pdir,
    input  logic dout,
    input  logic p_oe,
    input  logic p_out,
    input  logic p_pe,
    input  logic p_up,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_out,
    output logic pad_ie,
    output logic pad_pu,
    output logic pad_pd,
    output logic gpio_in,
    output logic per_in
);
    logic src_oe, src_out, src_ie, src_pe, src_up;

    // Select the source of the pin's requests.
    always_comb begin
        if (fsel) begin
            src_oe  = p_oe;
            src_out = p_out;
            src_ie  = 1'b1;
            src_pe  = p_pe;
            src_up  = p_up;
        end else if (CAP) begin
            src_oe  = oen;
            src_out = dout;
            src_ie  = ien;
            src_pe  = pen;
            src_up  = pdir;
        end else begin
            src_oe  = 1'b0;
            src_out = 1'b0;
            src_ie  = 1'b0;
            src_pe  = 1'b0;
            src_up  = 1'b0;
        end
    end

    // Apply the driver/pull rule to the selected requests.
    always_comb begin
        pad_oe  = src_oe;
        pad_out = src_oe & src_out;
        pad_ie  = src_ie;
        pad_pu  = ~src_oe & src_pe & src_up;
        pad_pd  = ~src_oe & src_pe & ~src_up;
        gpio_in = ~fsel & src_ie & pad_in;
        per_in  = fsel & pad_in;
    end
endmodule

// File: rtl/pinctl_bank.sv
// Top of the GPIO pin control bank.
// Register bus: a write lands on the clock edge. A read is registered and
// returns one cycle later with bus_rvalid. A read and a write in the same cycle
// return the value held before the write.
module pinctl_bank
    import pinctl_pkg::*;
#(
    parameter int               NPIN     = 8,
    parameter logic [NPIN-1:0]  CAP_MASK = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPIN-1:0]   pad_in,
    input  logic [NPIN-1:0]   per_oe,
    input  logic [NPIN-1:0]   per_out,
    input  logic [NPIN-1:0]   per_pull_en,
    input  logic [NPIN-1:0]   per_pull_up,
    output logic [NPIN-1:0]   per_in,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_ie,
    output logic [NPIN-1:0]   pad_pu,
    output logic [NPIN-1:0]   pad_pd
);
    logic [NPIN-1:0] ien, oen, pen, pdir, dout, fsel, gpio_in;
    logic [NPIN-1:0] rd_mux;

    pinctl_regs #(.NPIN(NPIN), .CAP_MASK(CAP_MASK)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ien   (ien),
        .oen   (oen),
        .pen   (pen),
        .pdir  (pdir),
        .dout  (dout),
        .fsel  (fsel)
    );

    genvar i;
    generate
        for (i = 0; i < NPIN; i++) begin : g_pin
            pinctl_pin #(.CAP(CAP_MASK[i])) u_pin (
                .fsel    (fsel[i]),
                .ien     (ien[i]),
                .oen     (oen[i]),
                .pen     (pen[i]),
                .pdir    (pdir[i]),
                .dout    (dout[i]),
                .p_oe    (per_oe[i]),
                .p_out   (per_out[i]),
                .p_pe    (per_pull_en[i]),
                .p_up    (per_pull_up[i]),
                .pad_in  (pad_in[i]),
                .pad_oe  (pad_oe[i]),
                .pad_out (pad_out[i]),
                .pad_ie  (pad_ie[i]),
                .pad_pu  (pad_pu[i]),
                .pad_pd  (pad_pd[i]),
                .gpio_in (gpio_in[i]),
                .per_in  (per_in[i])
            );
        end
    endgenerate

    // Select the addressed register for read-back.
    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_IEN:  rd_mux = ien;
            REG_OEN:  rd_mux = oen;
            REG_PEN:  rd_mux = pen;
            REG_PDIR: rd_mux = pdir;
            REG_DOUT: rd_mux = dout;
            REG_DIN:  rd_mux = gpio_in;
            REG_FSEL: rd_mux = fsel;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/pinctl_bank_chk.sv
// Checker for pinctl_bank: relates pad controls, function select and bus timing.
// Assumes: bound to every instance of pinctl_bank via the bind below.
module pinctl_bank_chk #(
    parameter int               NPIN     = 8,
    parameter logic [NPIN-1:0]  CAP_MASK = 8'h7F
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic            bus_rvalid,
    input logic [NPIN-1:0] fsel,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_ie,
    input logic [NPIN-1:0] pad_pu,
    input logic [NPIN-1:0] pad_pd
);
    assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    assert_read_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    assert_pull_off_driving_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pu | pad_pd)) == '0);
    assert_pull_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);
    assert_out_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);
    assert_noncap_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_ie | pad_pu | pad_pd | pad_out) & ~CAP_MASK & ~fsel) == '0);
    assert_periph_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel & ~pad_ie) == '0);
endmodule

bind pinctl_bank pinctl_bank_chk #(.NPIN(NPIN), .CAP_MASK(CAP_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .fsel       (fsel),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_ie     (pad_ie),
    .pad_pu     (pad_pu),
    .pad_pd     (pad_pd)
);

// File: tb/sim_pinctl_bank.sv
// Scoreboard bench for pinctl_bank: the read task queues expected data and a
// monitor compares it when bus_rvalid appears. Pad checks use a bench model.
module sim_pinctl_bank;
    localparam logic [7:0] CAP = 8'h7F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       bus_rvalid;
    logic [7:0] pad_in = '0, per_oe = '0, per_out = '0, per_pull_en = '0, per_pull_up = '0;
    logic [7:0] per_in, pad_oe, pad_out, pad_ie, pad_pu, pad_pd;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // Bench shadow of the registers, written from the requirements.
    logic [7:0] s_ien = 0, s_oen = 0, s_pen = 0, s_pdir = 0, s_dout = 0, s_fsel = 0;

    always #2 clk = ~clk;

    pinctl_bank #(.NPIN(8), .CAP_MASK(CAP)) u0 (.*);

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_din();
        return pad_in & s_ien & CAP & ~s_fsel;
    endfunction

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        case (a)
            3'd0: s_ien  = d & CAP;
            3'd1: s_oen  = d & CAP;
            3'd2: s_pen  = d & CAP;
            3'd3: s_pdir = d & CAP;
            3'd4: s_dout = d & CAP;
            3'd6: s_fsel = d;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, string tag);
        logic [7:0] e;
        case (a)
            3'd0: e = s_ien;
            3'd1: e = s_oen;
            3'd2: e = s_pen;
            3'd3: e = s_pdir;
            3'd4: e = s_dout;
            3'd5: e = exp_din();
            3'd6: e = s_fsel;
            default: e = 8'h00;
        endcase
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Compare the pad controls with the bench model at a quiet time.
    task automatic pads(string tag);
        logic [7:0] eoe, eout, eie, epu, epd, epi;
        for (int i = 0; i < 8; i++) begin
            logic o, e, u, ie;
            if (s_fsel[i]) begin
                o = per_oe[i]; e = per_pull_en[i]; u = per_pull_up[i]; ie = 1'b1;
                eout[i] = o & per_out[i];
            end else if (CAP[i]) begin
                o = s_oen[i]; e = s_pen[i]; u = s_pdir[i]; ie = s_ien[i];
                eout[i] = o & s_dout[i];
            end else begin
                o = 0; e = 0; u = 0; ie = 0; eout[i] = 0;
            end
            eoe[i] = o; eie[i] = ie;
            epu[i] = ~o & e & u;
            epd[i] = ~o & e & ~u;
            epi[i] = s_fsel[i] & pad_in[i];
        end
        @(negedge clk);
        check({tag, " pad_oe"}, pad_oe, eoe);
        check({tag, " pad_out"}, pad_out, eout);
        check({tag, " pad_ie"}, pad_ie, eie);
        check({tag, " pad_pu"}, pad_pu, epu);
        check({tag, " pad_pd"}, pad_pd, epd);
        check({tag, " per_in"}, per_in, epi);
    endtask

    // Monitor: pop an expected read value whenever read data is presented.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) check("R2 unexpected rvalid", 8'h01, 8'h00);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        pads("R1 reset");
        for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset read");
        rd(3'd7, "R2 unused address");
        // R6 / R7: input path, non-capable pin masked
        pad_in = 8'hA5;
        wr(3'd0, 8'hFF);
        rd(3'd0, "R7 ien masked");
        rd(3'd5, "R6 din all enabled");
        wr(3'd0, 8'h0F);
        rd(3'd5, "R6 din partly enabled");
        pads("R6 ie");
        // R4 / R5: pulls with driver off
        wr(3'd2, 8'h3C);
        wr(3'd3, 8'hF0);
        pads("R4 pull dir");
        rd(3'd3, "R4 pdir read");
        // R3: drive with conflicting bits
        wr(3'd4, 8'h5A);
        wr(3'd1, 8'h33);
        pads("R3 drive");
        // R9: write to input-data address ignored
        wr(3'd5, 8'hFF);
        rd(3'd5, "R9 din unchanged");
        rd(3'd1, "R9 oen unchanged");
        pads("R9 pads unchanged");
        // R7: all ones everywhere
        for (int a = 0; a < 5; a++) wr(3'(a), 8'hFF);
        pads("R7 all ones");
        for (int a = 0; a < 5; a++) rd(3'(a), "R7 readback");
        rd(3'd5, "R7 din");
        // R8: peripheral takes pins 7 and 6 and pin 0
        per_oe = 8'h81; per_out = 8'h80; per_pull_en = 8'h41; per_pull_up = 8'h40;
        wr(3'd6, 8'hC1);
        pads("R8 peripheral");
        rd(3'd6, "R8 fsel read");
        rd(3'd5, "R8 din gated");
        pad_in = 8'h3C;
        per_oe = 8'h00; per_pull_en = 8'hC1; per_pull_up = 8'h01;
        pads("R8 peripheral pulls");
        rd(3'd5, "R8 din new pad");
        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        s_ien = 0; s_oen = 0; s_pen = 0; s_pdir = 0; s_dout = 0; s_fsel = 0;
        @(negedge clk); rst_n = 1'b1;
        pads("R1 re-reset");
        rd(3'd1, "R1 oen after reset");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R2 reads outstanding", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule